// File: doc/BRIEF.md
# Flagged Integer ALU with Carry-Linked Single-Bit Shifts

This block is a purely combinational integer arithmetic and logic unit of configurable word width. It takes two operands, a carry input and a five-bit operation code. It returns a result word and five status bits: carry, zero, negative, overflow and parity. A surrounding datapath holds the operands and operation code stable for a clock period and captures the result and status bits at the next edge. A captured carry can be fed back as the carry input, so words wider than the ALU can be added, subtracted or shifted piece by piece.

Twenty operations are decoded. Seven are arithmetic and share one adder: add, add with carry, subtract, subtract with borrow, negate, increment and decrement. Five are logic operations: pass-through, AND, OR, XOR and inversion. Eight are single-bit shifts: arithmetic, logical, rotate and rotate-through-carry, each to the left and to the right. Every shift returns the departing bit on the carry output. All subtraction-type operations report a borrow on the carry output, with 1 meaning a borrow occurred. The remaining twelve codes are inert.

Top module: `flag_alu`

## Requirements
- R1: Code 0 (add) gives result = A + B and code 1 (add with carry) gives result = A + B + carry_in, both modulo 2^WIDTH; flag_c is the unsigned carry out of the top bit.
- R2: Code 2 (subtract) gives result = A - B and code 3 (subtract with borrow) gives result = A - B - carry_in, modulo 2^WIDTH; flag_c is 1 exactly when the unsigned minuend is smaller than the unsigned subtrahend (B, or B + carry_in).
- R3: Code 4 gives result = 0 - A with flag_c = 1 when A is nonzero. Code 5 gives result = A + 1 with flag_c = 1 when A is all ones. Code 6 gives result = A - 1 with flag_c = 1 when A is zero.
- R4: flag_v is 1 for codes 0 to 6 exactly when the true signed result lies outside the two's complement range of WIDTH bits; for every other code flag_v is 0.
- R5: Codes 7 to 11 give result = A, A AND B, A OR B, A XOR B and NOT A, in that order; flag_c is 0.
- R6: Code 12 (arithmetic left) and code 14 (logical left) give result = A shifted left by one with 0 entering bit 0; flag_c = A[WIDTH-1].
- R7: Code 13 (arithmetic right) fills the top bit with A[WIDTH-1]; code 15 (logical right) fills it with 0; both move A right by one and give flag_c = A[0].
- R8: Code 16 rotates A left by one, placing A[WIDTH-1] in bit 0. Code 17 rotates A right by one, placing A[0] in the top bit. In both cases flag_c is the bit that moved across the ends.
- R9: Code 18 moves A left by one with carry_in entering bit 0 and flag_c = A[WIDTH-1]; code 19 moves A right by one with carry_in entering the top bit and flag_c = A[0].
- R10: For codes 0 to 19, flag_z = 1 when every result bit is 0, flag_n = result[WIDTH-1], and flag_p = 1 when the result holds an odd number of ones.
- R11: Codes 20 to 31 give result = 0 with flag_c, flag_z, flag_n, flag_v and flag_p all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | WIDTH | First operand; the source of all single-operand and shift operations |
| opnd_b | input | WIDTH | Second operand |
| carry_in | input | 1 | Incoming carry or borrow; the bit inserted by rotate-through-carry |
| op_sel | input | 5 | Operation code, 0 to 19 decoded, 20 to 31 inert |
| result | output | WIDTH | Operation result |
| flag_c | output | 1 | Carry, borrow or shifted-out bit |
| flag_z | output | 1 | Result is all zeros |
| flag_n | output | 1 | Top bit of the result |
| flag_v | output | 1 | Signed overflow of an arithmetic operation |
| flag_p | output | 1 | Odd number of ones in the result |

## Verification
Two functions can act on the same operation. Carry and signed overflow can both be set by a single add or subtract. The rotate-through-carry operations consume carry_in and produce a new carry in the same evaluation. The bench provokes both cases with operand sets built around 0x7FFF, 0x8000, 0x8001 and 0xFFFF, with each carry_in value. A behavioural model computes the expected carry from unsigned integer ranges and the expected overflow from signed integer ranges, with no knowledge of the adder. A mismatch in either bit is reported against its own requirement.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  localparam int OPW = 5;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 5'd0,
    OP_ADC  = 5'd1,
    OP_SUB  = 5'd2,
    OP_SBB  = 5'd3,
    OP_NEG  = 5'd4,
    OP_INC  = 5'd5,
    OP_DEC  = 5'd6,
    OP_PASS = 5'd7,
    OP_AND  = 5'd8,
    OP_OR   = 5'd9,
    OP_XOR  = 5'd10,
    OP_NOT  = 5'd11,
    OP_SLA  = 5'd12,
    OP_SRA  = 5'd13,
    OP_SLL  = 5'd14,
    OP_SRL  = 5'd15,
    OP_ROL  = 5'd16,
    OP_ROR  = 5'd17,
    OP_RCL  = 5'd18,
    OP_RCR  = 5'd19
  } alu_op_e;

  typedef enum logic [1:0] {
    CLS_ARITH,
    CLS_LOGIC,
    CLS_SHIFT,
    CLS_NONE
  } op_class_e;

  // Map an operation code onto the unit that serves it.
  function automatic op_class_e classify(input logic [OPW-1:0] code);
    if (code <= OP_DEC)      return CLS_ARITH;
    else if (code <= OP_NOT) return CLS_LOGIC;
    else if (code <= OP_RCR) return CLS_SHIFT;
    else                     return CLS_NONE;
  endfunction

endpackage

// File: rtl/flag_alu_arith.sv
module flag_alu_arith
  import flag_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  input  logic [OPW-1:0]   code,
  output logic [WIDTH-1:0] res,
  output logic             carry,
  output logic             ovf
);

  localparam int MSB = WIDTH - 1;

  // One adder serves all seven arithmetic codes. Returns
  // {carry out of msb, carry into msb, sum}.
  function automatic logic [WIDTH+1:0] add_split(
    input logic [WIDTH-1:0] x,
    input logic [WIDTH-1:0] y,
    input logic             c
  );
    logic [WIDTH-1:0] lo;
    logic [1:0]       hi;
    lo = {1'b0, x[MSB-1:0]} + {1'b0, y[MSB-1:0]} + WIDTH'(c);
    hi = {1'b0, x[MSB]} + {1'b0, y[MSB]} + {1'b0, lo[MSB]};
    return {hi[1], lo[MSB], hi[0], lo[MSB-1:0]};
  endfunction

  logic [WIDTH-1:0] add_x;
  logic [WIDTH-1:0] add_y;
  logic             add_c;
  logic             borrow_mode;
  logic [WIDTH+1:0] add_out;
  logic             carry_top;
  logic             carry_into_top;

  always_comb begin
    add_x       = a;
    add_y       = '0;
    add_c       = 1'b0;
    borrow_mode = 1'b0;
    unique case (code)
      OP_ADD: add_y = b;
      OP_ADC: begin add_y = b; add_c = cin; end
      OP_SUB: begin add_y = ~b; add_c = 1'b1; borrow_mode = 1'b1; end
      OP_SBB: begin add_y = ~b; add_c = ~cin; borrow_mode = 1'b1; end
      OP_NEG: begin add_x = '0; add_y = ~a; add_c = 1'b1; borrow_mode = 1'b1; end
      OP_INC: add_c = 1'b1;
      OP_DEC: begin add_y = '1; borrow_mode = 1'b1; end
      default: add_x = '0;
    endcase
  end

  assign add_out        = add_split(add_x, add_y, add_c);
  assign carry_top      = add_out[WIDTH+1];
  assign carry_into_top = add_out[WIDTH];
  assign res            = add_out[WIDTH-1:0];
  assign carry          = carry_top ^ borrow_mode;
  assign ovf            = carry_top ^ carry_into_top;

  always_comb begin
    if (!$isunknown({a, b, cin, code})) begin
      if (code == OP_SUB) begin
        // R2
        borrow_cmp_chk: assert (carry == (a < b));
      end
      if (code == OP_ADD && ovf) begin
        // R4
        add_ovf_sign_chk: assert (a[MSB] == b[MSB] && res[MSB] != a[MSB]);
      end
      if (code == OP_INC) begin
        // R3
        inc_wrap_chk: assert (carry == (res == '0));
      end
    end
  end

endmodule

// File: rtl/flag_alu_logic.sv
module flag_alu_logic
  import flag_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [OPW-1:0]   code,
  output logic [WIDTH-1:0] res
);

  always_comb begin
    unique case (code)
      OP_PASS: res = a;
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_NOT:  res = ~a;
      default: res = '0;
    endcase
  end

  always_comb begin
    if (!$isunknown({a, b, code}) && code == OP_XOR) begin
      // R5
      xor_self_chk: assert ((res ^ b) == a);
    end
  end

endmodule

// File: rtl/flag_alu_shift.sv
module flag_alu_shift
  import flag_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic             cin,
  input  logic [OPW-1:0]   code,
  output logic [WIDTH-1:0] res,
  output logic             carry
);

  localparam int MSB = WIDTH - 1;

  logic go_left;
  logic fill_bit;
  logic out_bit;

  always_comb begin
    go_left  = 1'b0;
    fill_bit = 1'b0;
    unique case (code)
      OP_SLA, OP_SLL: go_left = 1'b1;
      OP_SRA:         fill_bit = a[MSB];
      OP_SRL:         fill_bit = 1'b0;
      OP_ROL:         begin go_left = 1'b1; fill_bit = a[MSB]; end
      OP_ROR:         fill_bit = a[0];
      OP_RCL:         begin go_left = 1'b1; fill_bit = cin; end
      OP_RCR:         fill_bit = cin;
      default:        fill_bit = 1'b0;
    endcase
  end

  assign out_bit = go_left ? a[MSB] : a[0];
  assign res     = go_left ? {a[MSB-1:0], fill_bit} : {fill_bit, a[MSB:1]};
  assign carry   = out_bit;

  always_comb begin
    if (!$isunknown({a, cin, code})) begin
      if (code == OP_ROL || code == OP_ROR) begin
        // R8
        rotate_conserve_chk: assert ($countones(res) == $countones(a));
      end
      if (code == OP_SRA) begin
        // R7
        sra_sign_keep_chk: assert (res[MSB] == a[MSB] && carry == a[0]);
      end
      if (code == OP_RCL || code == OP_RCR) begin
        // R9
        rc_conserve_chk: assert ($countones({res, carry}) == $countones({a, cin}));
      end
    end
  end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic             carry_in,
  input  logic [OPW-1:0]   op_sel,
  output logic [WIDTH-1:0] result,
  output logic             flag_c,
  output logic             flag_z,
  output logic             flag_n,
  output logic             flag_v,
  output logic             flag_p
);

  localparam int MSB = WIDTH - 1;

  op_class_e        op_cls;
  logic             op_known;
  logic [WIDTH-1:0] ar_res;
  logic             ar_carry;
  logic             ar_ovf;
  logic [WIDTH-1:0] lg_res;
  logic [WIDTH-1:0] sh_res;
  logic             sh_carry;

  assign op_cls   = classify(op_sel);
  assign op_known = (op_cls != CLS_NONE);

  flag_alu_arith #(.WIDTH(WIDTH)) arith_u (
    .a(opnd_a), .b(opnd_b), .cin(carry_in), .code(op_sel),
    .res(ar_res), .carry(ar_carry), .ovf(ar_ovf)
  );

  flag_alu_logic #(.WIDTH(WIDTH)) logic_u (
    .a(opnd_a), .b(opnd_b), .code(op_sel), .res(lg_res)
  );

  flag_alu_shift #(.WIDTH(WIDTH)) shift_u (
    .a(opnd_a), .cin(carry_in), .code(op_sel),
    .res(sh_res), .carry(sh_carry)
  );

  always_comb begin
    unique case (op_cls)
      CLS_ARITH: begin result = ar_res; flag_c = ar_carry; end
      CLS_LOGIC: begin result = lg_res; flag_c = 1'b0;     end
      CLS_SHIFT: begin result = sh_res; flag_c = sh_carry; end
      default:   begin result = '0;     flag_c = 1'b0;     end
    endcase
  end

  assign flag_v = (op_cls == CLS_ARITH) & ar_ovf;
  assign flag_z = op_known & ~|result;
  assign flag_n = op_known & result[MSB];
  assign flag_p = op_known & ^result;

  always_comb begin
    if (!$isunknown({opnd_a, opnd_b, carry_in, op_sel})) begin
      if (op_cls != CLS_ARITH) begin
        // R4
        no_overflow_chk: assert (!flag_v);
      end
      if (!op_known) begin
        // R11
        unused_quiet_chk: assert (result == '0 && !flag_c && !flag_z && !flag_n && !flag_p);
      end
      if (flag_p) begin
        // R10
        parity_nonzero_chk: assert (!flag_z);
      end
    end
  end

endmodule

// File: tb/flag_alu_tb_top.sv
`timescale 1ns/1ps
module flag_alu_tb_top;

  localparam int W = 16;
  localparam longint MODV = 64'd1 << W;
  localparam longint TOPV = 64'd1 << (W - 1);

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a_d = '0;
  logic [W-1:0] b_d = '0;
  logic         ci_d = 1'b0;
  logic [4:0]   op_d = '0;
  logic [W-1:0] y_q;
  logic         c_q, z_q, n_q, v_q, p_q;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  flag_alu #(.WIDTH(W)) dut_i (
    .opnd_a(a_d), .opnd_b(b_d), .carry_in(ci_d), .op_sel(op_d),
    .result(y_q), .flag_c(c_q), .flag_z(z_q), .flag_n(n_q),
    .flag_v(v_q), .flag_p(p_q)
  );

  function automatic longint sgn(input longint x);
    return (x >= TOPV) ? x - MODV : x;
  endfunction

  function automatic string tag_of(input int op);
    if (op <= 1)  return "R1";
    if (op <= 3)  return "R2";
    if (op <= 6)  return "R3";
    if (op <= 11) return "R5";
    if (op == 12 || op == 14) return "R6";
    if (op == 13 || op == 15) return "R7";
    if (op <= 17) return "R8";
    if (op <= 19) return "R9";
    return "R11";
  endfunction

  // Behavioural reference, written over integer ranges.
  task automatic model(input int op, input longint a, input longint b, input int ci,
                       output longint y, output int c, output int v);
    longint t;
    longint sv;
    sv = 0; t = 0; c = 0; v = 0; y = 0;
    case (op)
      0:  begin t = a + b;      sv = sgn(a) + sgn(b);      c = int'(t >= MODV); end
      1:  begin t = a + b + ci; sv = sgn(a) + sgn(b) + ci; c = int'(t >= MODV); end
      2:  begin t = a - b;      sv = sgn(a) - sgn(b);      c = int'(t < 0); end
      3:  begin t = a - b - ci; sv = sgn(a) - sgn(b) - ci; c = int'(t < 0); end
      4:  begin t = -a;         sv = -sgn(a);              c = int'(a != 0); end
      5:  begin t = a + 1;      sv = sgn(a) + 1;           c = int'(t >= MODV); end
      6:  begin t = a - 1;      sv = sgn(a) - 1;           c = int'(t < 0); end
      7:  t = a;
      8:  t = a & b;
      9:  t = a | b;
      10: t = a ^ b;
      11: t = MODV - 1 - a;
      12, 14: begin c = int'(a / TOPV); t = (a * 2) % MODV; end
      13: begin c = int'(a % 2); t = a / 2 + ((a >= TOPV) ? TOPV : 0); end
      15: begin c = int'(a % 2); t = a / 2; end
      16: begin c = int'(a / TOPV); t = (a * 2) % MODV + c; end
      17: begin c = int'(a % 2); t = a / 2 + c * TOPV; end
      18: begin c = int'(a / TOPV); t = (a * 2) % MODV + ci; end
      19: begin c = int'(a % 2); t = a / 2 + ci * TOPV; end
      default: t = 0;
    endcase
    y = ((t % MODV) + MODV) % MODV;
    if (op <= 6) v = int'(sv < -TOPV || sv > TOPV - 1);
  endtask

  task automatic run(input int op, input longint a, input longint b, input int ci);
    longint ey;
    int ec, ev, ez, en, ep, ones;
    bit known;
    @(posedge clk);
    op_d = op[4:0]; a_d = a[W-1:0]; b_d = b[W-1:0]; ci_d = ci[0];
    @(negedge clk);
    model(op, a, b, ci, ey, ec, ev);
    known = (op < 20);
    ones = 0;
    for (int i = 0; i < W; i++) ones += int'((ey >> i) & 1);
    ez = int'(known && ey == 0);
    en = int'(known && ey >= TOPV);
    ep = int'(known && (ones % 2 == 1));
    // result and carry, tagged by the operation's requirement
    checks++;
    if (longint'(y_q) != ey || int'(c_q) != ec) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h ci=%0d: actual y=%h c=%0d expected y=%h c=%0d",
               tag_of(op), op, a, b, ci, y_q, c_q, ey, ec);
    end
    // R4 overflow
    checks++;
    if (int'(v_q) != ev) begin
      errors++;
      $display("FAIL R4 op=%0d a=%h b=%h ci=%0d: actual v=%0d expected v=%0d",
               op, a, b, ci, v_q, ev);
    end
    // R10 (R11 for inert codes) zero, negative, parity
    checks++;
    if (int'(z_q) != ez || int'(n_q) != en || int'(p_q) != ep) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h: actual z=%0d n=%0d p=%0d expected z=%0d n=%0d p=%0d",
               known ? "R10" : "R11", op, a, b, z_q, n_q, p_q, ez, en, ep);
    end
  endtask

  longint corners [8] = '{64'h0000, 64'h0001, 64'h7FFF, 64'h8000,
                          64'hFFFF, 64'hAAAA, 64'h5555, 64'h8001};

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // Reset-state check: all-zero inputs, add: result 0, zero flag set (R1, R10)
    run(0, 0, 0, 0);
    // Carry and overflow together, rotate-through-carry in and out (R1 R2 R4 R9)
    run(0, 64'h8000, 64'h8000, 0);
    run(3, 64'h8000, 64'h0000, 1);
    run(18, 64'h8001, 0, 1);
    run(19, 64'h8001, 0, 0);
    // Inert code (R11)
    run(25, 64'hFFFF, 64'hFFFF, 1);
    for (int op = 0; op < 32; op++)
      for (int ia = 0; ia < 8; ia++)
        for (int ib = 0; ib < 8; ib++)
          for (int ci = 0; ci < 2; ci++)
            run(op, corners[ia], corners[ib], ci);
    for (int k = 0; k < 3000; k++)
      run(int'($urandom % 32), longint'($urandom & 32'hFFFF),
          longint'($urandom & 32'hFFFF), int'($urandom % 2));
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=not finished expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule